// File: doc/BRIEF.md
# Time-Sliced Single-Port FIFO

This block is a first-in first-out buffer of sixteen 32-bit words held in one single-port RAM. One read and one write can both be requested in the same bus cycle, even though the RAM allows only one access at a time. The block runs on a fast clock at twice the bus rate and cuts every bus cycle into two slots. The first slot serves the read and the second slot serves the write, so a pop always happens before a push. To the requesters, the two operations in one bus cycle look simultaneous, and they never have to test whether the memory is busy.

The block drives the `bus_phase` output, and this output defines the bus cycle. Requests are sampled on the fast clock edge that ends a cycle in which `bus_phase` is high. That edge is the end of the write slot and the start of the next bus cycle.

The write side is a valid/ready stream. A word is taken only when `in_valid` and `in_ready` are both high at a sampling edge. The block lowers `in_ready` while it holds sixteen words, and a word offered at that time is dropped. It is not stalled or queued, so a producer must hold its word until it sees `in_ready` high at a sampling edge.

The read side has a plain `pop_req` strobe together with the `status` flag. The popped word is registered and shown on two identical output ports: one for the transaction-control side and one for the receive/transmit side. It stays there until the next successful pop.

Top module: `tslice_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `status` low, `in_ready` high, both read-data ports at zero, and `bus_phase` low in the first cycle after the reset edge.
- R2: `bus_phase` alternates on every fast clock edge. Requests are sampled only on edges that end a cycle with `bus_phase` high.
- R3: Words come out in the order they were accepted. Storage wraps through all sixteen locations without loss across any number of fill and drain rounds.
- R4: `status` is high exactly when at least one word is stored. It changes at the sampling edge of the request that changes the fill level.
- R5: `in_ready` is low exactly when sixteen words are stored. An `in_valid` presented while `in_ready` is low is dropped, and the stored contents and their order stay the same.
- R6: A `pop_req` while empty is ignored. Both read-data ports keep their previous value and `status` stays low.
- R7: Push and pop in one bus cycle while not empty returns the oldest word and stores the new one, so the fill level is unchanged.
- R8: Push and pop in one bus cycle while empty stores the new word only. The read-data ports do not change and `status` goes high.
- R9: A popped word appears on both read-data ports with the same value, two fast edges after its sampling edge. It is held there until the next successful pop.
- R10: The RAM is never written during a read slot (`bus_phase` low) and never read during a write slot.
- R11: Push and pop in one bus cycle while full performs only the pop, because `in_ready` was low. The fill level drops to fifteen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_2x | input | 1 | Fast clock at twice the bus rate |
| rst | input | 1 | Synchronous reset, active high |
| bus_phase | output | 1 | High during the write slot; its falling edge marks a bus-cycle boundary |
| in_valid | input | 1 | Push request with a word on `in_data` |
| in_ready | output | 1 | High when a word can be accepted (fewer than 16 stored) |
| in_data | input | 32 | Word to push |
| pop_req | input | 1 | Pop request strobe |
| status | output | 1 | High when the FIFO holds at least one word |
| tc_rdata | output | 32 | Popped word, transaction-control side |
| rt_rdata | output | 32 | Popped word, receive/transmit side |

## Verification
The bench targets push and pop in the same bus cycle in three states: empty, partly filled and full. A design that popped after pushing would return the new word from an empty buffer. A design that ignored the full state would overwrite the oldest entry. It also fills the buffer, offers a word while it is full, and then drains across the wrap point of the pointers. If a pointer wrapped wrongly, or the full and empty decisions were swapped, words would come out in the wrong order. Pops on an empty buffer and reset partway through a run are included, and so is the slot alternation. A write that leaked into the read slot would corrupt the word being read.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  // which half of the bus cycle the RAM is serving
  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;

  // wrap-around increment for a pointer of arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/tsf_slot_seq.sv
module tsf_slot_seq
  import tsf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot,
  output logic  bus_end
);

  slot_e slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= SLOT_RD;
    else     slot_q <= (slot_q == SLOT_RD) ? SLOT_WR : SLOT_RD;
  end

  assign slot    = slot_q;
  assign bus_end = (slot_q == SLOT_WR);

  // R2: the slot toggles on every edge
  assert_slot_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slot_q != $past(slot_q));

endmodule

// File: rtl/tsf_ptr_ctrl.sv
module tsf_ptr_ctrl
  import tsf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_end,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          pop_req,
  output logic          in_ready,
  output logic          status,
  output logic          rd_go,
  output logic          wr_go,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] level;
  logic          do_pop, do_push;

  // pop is decided on the level before this cycle's push, so an empty
  // buffer never returns the word arriving in the same bus cycle
  always_comb begin
    do_pop  = pop_req  && (level != '0);
    do_push = in_valid && (level != FULL_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      level   <= '0;
      rd_go   <= 1'b0;
      wr_go   <= 1'b0;
      rd_addr <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (bus_end) begin
      rd_go   <= do_pop;
      wr_go   <= do_push;
      rd_addr <= rd_ptr;
      wr_addr <= wr_ptr;
      if (do_push) begin
        wr_data <= in_data;
        wr_ptr  <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      end
      if (do_pop) rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  assign in_ready = (level != FULL_LVL);
  assign status   = (level != '0);

  // R5: the level never passes the depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  // R3: equal pointers mean empty or full, nothing else
  assert_ptr_level_R3: assert property (@(posedge clk) disable iff (rst)
    ((level == '0) || (level == FULL_LVL)) == (wr_ptr == rd_ptr));

  // R5: a rejected push leaves the write pointer alone
  assert_full_push_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_end && in_valid && !in_ready) |=> wr_ptr == $past(wr_ptr));

  // R6: a pop on empty leaves the read pointer alone
  assert_empty_pop_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_end && pop_req && !status) |=> rd_ptr == $past(rd_ptr));

  // R2: pointers only move at a bus-cycle boundary
  assert_ptrs_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_end |=> ($stable(rd_ptr) && $stable(wr_ptr) && $stable(level)));

endmodule

// File: rtl/tsf_spram.sv
module tsf_spram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // one port: a cycle either writes or reads, never both
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/tslice_fifo.sv
module tslice_fifo
  import tsf_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_OUT = 2,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_2x,
  input  logic          rst,
  output logic          bus_phase,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop_req,
  output logic          status,
  output logic [DW-1:0] tc_rdata,
  output logic [DW-1:0] rt_rdata
);

  slot_e         slot;
  logic          bus_end;
  logic          rd_go, wr_go;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data, ram_q;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic          rd_done;
  logic [DW-1:0] out_q [NUM_OUT];

  tsf_slot_seq u_seq (
    .clk     (clk_2x),
    .rst     (rst),
    .slot    (slot),
    .bus_end (bus_end)
  );

  tsf_ptr_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk      (clk_2x),
    .rst      (rst),
    .bus_end  (bus_end),
    .in_valid (in_valid),
    .in_data  (in_data),
    .pop_req  (pop_req),
    .in_ready (in_ready),
    .status   (status),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // slot mux: read slot first, write enable held low until the write slot
  always_comb begin
    if (slot == SLOT_RD) begin
      ram_en   = rd_go;
      ram_we   = 1'b0;
      ram_addr = rd_addr;
    end else begin
      ram_en   = wr_go;
      ram_we   = wr_go;
      ram_addr = wr_addr;
    end
  end

  tsf_spram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk   (clk_2x),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (wr_data),
    .rdata (ram_q)
  );

  always_ff @(posedge clk_2x) begin
    if (rst) rd_done <= 1'b0;
    else     rd_done <= ram_en && !ram_we;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    always_ff @(posedge clk_2x) begin
      if (rst)          out_q[g] <= '0;
      else if (rd_done) out_q[g] <= ram_q;
    end

    // R9: a port changes only after a completed read
    assert_out_hold_R9: assert property (@(posedge clk_2x) disable iff (rst)
      !rd_done |=> $stable(out_q[g]));
  end

  assign bus_phase = (slot == SLOT_WR);
  assign tc_rdata  = out_q[0];
  assign rt_rdata  = out_q[NUM_OUT-1];

  // R10: no write reaches the RAM while the read slot is active
  assert_no_write_in_read_slot_R10: assert property (@(posedge clk_2x) disable iff (rst)
    !bus_phase |-> !ram_we);

  // R10: a read finishing always came from a read slot
  assert_read_only_in_read_slot_R10: assert property (@(posedge clk_2x) disable iff (rst)
    rd_done |-> bus_phase);

  // R9: both consumer ports agree
  assert_ports_match_R9: assert property (@(posedge clk_2x) disable iff (rst)
    tc_rdata == rt_rdata);

endmodule

// File: tb/tslice_fifo_bench.sv
module tslice_fifo_bench;

  localparam int DEPTH = 16;
  localparam int NVEC  = 9;
  // {push, pop, wdata[31:0], exp_status, exp_ready, exp_rdata[31:0]}
  localparam logic [67:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'h1111_0001, 1'b1, 1'b1, 32'h0000_0000},
    {1'b1, 1'b0, 32'h1111_0002, 1'b1, 1'b1, 32'h0000_0000},
    {1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b1, 32'h1111_0001},
    {1'b1, 1'b1, 32'h1111_0003, 1'b1, 1'b1, 32'h1111_0002},
    {1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 32'h1111_0003},
    {1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 32'h1111_0003},
    {1'b1, 1'b1, 32'h1111_0004, 1'b1, 1'b1, 32'h1111_0003},
    {1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 32'h1111_0003},
    {1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 32'h1111_0004}
  };

  logic        clk_2x = 1'b0;
  logic        rst;
  logic        bus_phase;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        pop_req;
  logic        status;
  logic [31:0] tc_rdata;
  logic [31:0] rt_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [$];
  logic [31:0] last_out = '0;

  always #2 clk_2x = ~clk_2x;

  tslice_fifo u_tslice_fifo (
    .clk_2x    (clk_2x),
    .rst       (rst),
    .bus_phase (bus_phase),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .pop_req   (pop_req),
    .status    (status),
    .tc_rdata  (tc_rdata),
    .rt_rdata  (rt_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; pop_req = 1'b0; in_data = '0;
    repeat (3) @(posedge clk_2x);
    @(negedge clk_2x);
    rst = 1'b0;
    model.delete();
    last_out = '0;
  endtask

  // one bus-cycle request, then wait until the popped word is visible
  task automatic bus_op(input logic push, input logic pop, input logic [31:0] d);
    @(negedge clk_2x);
    while (!bus_phase) @(negedge clk_2x);
    in_valid = push; pop_req = pop; in_data = d;
    @(posedge clk_2x);
    @(negedge clk_2x);
    in_valid = 1'b0; pop_req = 1'b0; in_data = '0;
    @(posedge clk_2x);
    @(posedge clk_2x);
    @(negedge clk_2x);
  endtask

  // model-driven op with checks on every port
  task automatic op_check(input string req, input logic push, input logic pop, input logic [31:0] d);
    bit can_pop, can_push;
    can_pop  = pop && (model.size() > 0);
    can_push = push && (model.size() < DEPTH);
    if (can_pop) last_out = model.pop_front();
    if (can_push) model.push_back(d);
    bus_op(push, pop, d);
    check({req, " status (R4)"}, 32'(status), 32'(model.size() > 0));
    check({req, " ready (R5)"}, 32'(in_ready), 32'(model.size() < DEPTH));
    check({req, " tc data (R3/R9)"}, tc_rdata, last_out);
    check({req, " rt data (R9)"}, rt_rdata, last_out);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_2x);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1 reset state
    check("R1 bus_phase", 32'(bus_phase), 32'd0);
    check("R1 status", 32'(status), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);
    check("R1 tc_rdata", tc_rdata, 32'd0);
    check("R1 rt_rdata", rt_rdata, 32'd0);

    // R2 slot alternation
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_2x);
      check("R2 phase toggle", 32'(bus_phase), 32'(i % 2 == 0));
    end

    // vector table: R7 (row 4), R6 (row 6), R8 (row 7)
    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      bus_op(VEC[i][67], VEC[i][66], VEC[i][65:34]);
      check($sformatf("R4 vec%0d status", i), 32'(status), 32'(VEC[i][33]));
      check($sformatf("R5 vec%0d ready", i), 32'(in_ready), 32'(VEC[i][32]));
      check($sformatf("R7/R8/R6 vec%0d tc", i), tc_rdata, VEC[i][31:0]);
      check($sformatf("R9 vec%0d rt", i), rt_rdata, VEC[i][31:0]);
    end

    // offset pointers, then fill to full (R5) across the wrap point (R3)
    do_reset();
    for (int i = 0; i < 5; i++) op_check("R3 offset push", 1'b1, 1'b0, 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 5; i++) op_check("R3 offset pop", 1'b0, 1'b1, '0);
    for (int i = 0; i < DEPTH; i++) op_check("R3 fill", 1'b1, 1'b0, 32'hB000_0000 + 32'(i));
    check("R5 full ready low", 32'(in_ready), 32'd0);
    op_check("R5 push while full", 1'b1, 1'b0, 32'hDEAD_BEEF);
    op_check("R11 push+pop while full", 1'b1, 1'b1, 32'hDEAD_0011);
    check("R11 one slot free", 32'(in_ready), 32'd1);
    op_check("R7 push+pop partial", 1'b1, 1'b1, 32'hC000_0001);
    for (int i = 0; i < DEPTH; i++) op_check("R3 drain", 1'b0, 1'b1, '0);
    op_check("R6 pop empty", 1'b0, 1'b1, '0);
    op_check("R8 push+pop empty", 1'b1, 1'b1, 32'hE000_0008);
    op_check("R8 drain", 1'b0, 1'b1, '0);

    // R1 reset mid-run clears everything
    op_check("R1 prefill", 1'b1, 1'b0, 32'hF000_0001);
    op_check("R1 prefill pop", 1'b1, 1'b1, 32'hF000_0002);
    do_reset();
    check("R1 mid status", 32'(status), 32'd0);
    check("R1 mid ready", 32'(in_ready), 32'd1);
    check("R1 mid tc", tc_rdata, 32'd0);
    op_check("R1 post-reset push", 1'b1, 1'b0, 32'h5555_0001);
    op_check("R1 post-reset pop", 1'b0, 1'b1, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule